// File: doc/BRIEF.md
# Three-Channel Programmable Sound Generator

This block produces three square-wave tone channels and one shared pseudo-random noise source. A per-channel mixer combines tone and noise, and each channel is then scaled by a 4-bit amplitude. That amplitude is either a fixed level or the output of a shared envelope generator. Sixteen 8-bit registers hold the whole configuration, and a host sets them over a simple address/data bus. The block has three 4-bit amplitude codes and their sum as outputs, ready for a digital-to-analogue stage outside the block. It also provides two general-purpose byte ports, and a mixer-register bit sets the direction of each port.

All timing advances only on cycles where the clock-enable input `tick` is high. The host writes a register with `bus_we`, `bus_addr` and `bus_wdata`, and the write takes effect at the next clock edge. Reads are combinational from `bus_addr`.

Top module: `psg3_core`

## Requirements
- R1: While `rst_n` is low, every register clears to 0. After reset, `amp_a`, `amp_b`, `amp_c` and `amp_sum` are 0, both port outputs are 0 and both port enables are 0, and reading addresses 0 to 13 returns 0.
- R2: Reading a register returns the last value written to it, with unused bits forced to 0:
  - addresses 1, 3, 5 and 13 keep bits [3:0] only;
  - addresses 6, 8, 9 and 10 keep bits [4:0] only;
  - all other addresses keep all 8 bits.
- R3: The tone period of channel A, B or C is P = {coarse[3:0], fine[7:0]}. Fine sits at address 0, 2 or 4 and coarse at the next address up. A P of 0 acts as 1.
  - Each tone bit starts at 0 after reset.
  - It toggles on every 16·P-th cycle in which `tick` is high.
  - With `tick` low, no tone bit changes.
- R4: The noise bit is bit 0 of a 17-bit shift register with seed 1 after reset. Address 6 holds the noise period N, where 0 acts as 1.
  - On every 16·N-th tick, the register shifts right, and the new bit 16 is the XOR of the old bits 0 and 3.
  - As a result, the noise bit is 1 until the first shift, 0 for the next 16 shifts, and 1 again after the 17th shift.
- R5: Address 7 is the mixer, and its enables are active low:
  - bits 0, 1 and 2 disable tone on A, B and C;
  - bits 3, 4 and 5 disable noise on A, B and C.
  - A channel is on when (tone bit OR tone disabled) AND (noise bit OR noise disabled). A channel that is off outputs 0.
- R6: Addresses 8, 9 and 10 are the volumes of A, B and C. If bit 4 is 0, an on channel outputs bits [3:0]. If bit 4 is 1, it outputs the envelope level and bits [3:0] are ignored.
- R7: The envelope period E = {address 12, address 11} (0 acts as 1) sets a step every 16·E ticks. The shape at address 13 uses four bits: bit 3 continue, bit 2 attack, bit 1 alternate, bit 0 hold.
  - A ramp runs 16 levels, upward if attack is 1 and downward otherwise.
  - At the end of a ramp:
    - if continue is 0, the level holds at 0;
    - if continue and hold are both 1, the level holds at its last value, inverted when alternate is 1;
    - otherwise a new ramp starts, in the opposite direction when alternate is 1.
- R8: A write to address 13 restarts the envelope at the next edge. The level becomes 0 if the written attack bit is 1 and 15 if it is 0, and the step timer clears. After reset, the envelope level is 15, which is the initial phase of shape 0.
- R9: Ports A and B use addresses 14 and 15, with direction set by mixer bits 6 and 7.
  - A write to a port address always lands in that port's latch.
  - `port_a_out` and `port_b_out` always drive the latch.
  - `port_a_oe` and `port_b_oe` equal the direction bits.
  - A read returns the latch when the direction bit is 1 (output) and the input pins when it is 0 (input).
- R10: `amp_sum` equals `amp_a` + `amp_b` + `amp_c` in every cycle, with a range of 0 to 45.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Clock enable for all tone, noise and envelope timing |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| port_a_in | input | 8 | Port A input pins |
| port_b_in | input | 8 | Port B input pins |
| port_a_out | output | 8 | Port A latch value |
| port_a_oe | output | 1 | Port A drive enable |
| port_b_out | output | 8 | Port B latch value |
| port_b_oe | output | 1 | Port B drive enable |
| amp_a | output | 4 | Channel A amplitude code |
| amp_b | output | 4 | Channel B amplitude code |
| amp_c | output | 4 | Channel C amplitude code |
| amp_sum | output | 6 | Sum of the three amplitude codes |

## Verification
The bench goes after the edges of the divider.

- **Tone timing.** The bench checks the tick just before and the tick at the toggle for periods 0, 1, 2 and 3, and for a coarse-only period of 256. A divider that is off by one, or that treats period 0 as 4096, misses these by a tick.
- **Envelope shapes.** For eight envelope shapes, the bench samples the level at the end of the first ramp and one and two steps later. A wrong inversion or hold rule then gives 0 where 15 is expected.
- **Restart.** The bench checks that a shape rewrite restarts the envelope.
- **Noise.** The bench checks the first shifts of the noise register against its stated seed and taps.
- **Ports.** Each port is read back in both directions, which exposes a read mux that ignores the direction bit.

// File: rtl/psg3_pkg.sv
// Package: shared sizes, register indices and field positions for the
// three-channel sound generator. Assumes a 16-entry, 8-bit register map.
package psg3_pkg;
    localparam int NUM_CH    = 3;
    localparam int NUM_REGS  = 16;
    localparam int ADDR_W    = $clog2(NUM_REGS);
    localparam int TONE_W    = 12;
    localparam int NOISE_W   = 5;
    localparam int ENV_W     = 16;
    localparam int AMP_W     = 4;
    localparam int VOL_W     = 5;
    localparam int LFSR_W    = 17;
    localparam int LFSR_TAP  = 3;
    localparam int PRESCALE  = 16;
    localparam int SUM_W     = AMP_W + $clog2(NUM_CH + 1);

    localparam int REG_NOISE = 6;
    localparam int REG_MIX   = 7;
    localparam int REG_VOL0  = 8;
    localparam int REG_EFINE = 11;
    localparam int REG_ECRS  = 12;
    localparam int REG_SHAPE = 13;
    localparam int REG_PORTA = 14;
    localparam int REG_PORTB = 15;

    localparam int SH_HOLD   = 0;
    localparam int SH_ALT    = 1;
    localparam int SH_ATTACK = 2;
    localparam int SH_CONT   = 3;

    localparam int MIX_DIR_A = 6;
    localparam int MIX_DIR_B = 7;

    // Bits kept by each register; unused bits read back as zero.
    function automatic logic [7:0] reg_keep(input logic [ADDR_W-1:0] a);
        case (a)
            4'd1, 4'd3, 4'd5, 4'd13: reg_keep = 8'h0F;
            4'd6, 4'd8, 4'd9, 4'd10: reg_keep = 8'h1F;
            default:                 reg_keep = 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/psg3_regs.sv
// Register file: holds the sixteen configuration bytes, masks unused bits,
// splits fields out for the datapath and muxes read data. Assumes writes
// take effect at the clock edge where bus_we is high.
module psg3_regs
    import psg3_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_we,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [7:0]                        bus_wdata,
    output logic [7:0]                        bus_rdata,
    input  logic [7:0]                        port_a_in,
    input  logic [7:0]                        port_b_in,
    output logic [NUM_CH-1:0][TONE_W-1:0]     tone_per,
    output logic [NOISE_W-1:0]                noise_per,
    output logic [7:0]                        mixer,
    output logic [NUM_CH-1:0][VOL_W-1:0]      vol,
    output logic [ENV_W-1:0]                  env_per,
    output logic [3:0]                        env_shape,
    output logic [7:0]                        port_a_lat,
    output logic [7:0]                        port_b_lat
);
    logic [7:0] regs [NUM_REGS];

    // Store masked write data; clear all registers on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else if (bus_we) begin
            regs[bus_addr] <= bus_wdata & reg_keep(bus_addr);
        end
    end

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_fields
            assign tone_per[ch] = {regs[2*ch+1][3:0], regs[2*ch]};
            assign vol[ch]      = regs[REG_VOL0+ch][VOL_W-1:0];
        end
    endgenerate

    assign noise_per  = regs[REG_NOISE][NOISE_W-1:0];
    assign mixer      = regs[REG_MIX];
    assign env_per    = {regs[REG_ECRS], regs[REG_EFINE]};
    assign env_shape  = regs[REG_SHAPE][3:0];
    assign port_a_lat = regs[REG_PORTA];
    assign port_b_lat = regs[REG_PORTB];

    // Read mux: ports return pins when configured as inputs.
    always_comb begin
        if (bus_addr == ADDR_W'(REG_PORTA))
            bus_rdata = regs[REG_MIX][MIX_DIR_A] ? regs[REG_PORTA] : port_a_in;
        else if (bus_addr == ADDR_W'(REG_PORTB))
            bus_rdata = regs[REG_MIX][MIX_DIR_B] ? regs[REG_PORTB] : port_b_in;
        else
            bus_rdata = regs[bus_addr];
    end
endmodule

// File: rtl/psg3_tone.sv
// Tone divider: toggles a square-wave bit every PRE*period enabled ticks.
// Assumes a period of zero behaves as one; the counter is not cleared on
// period writes, so a shortened period wraps at the next enabled tick.
module psg3_tone #(
    parameter int PER_W = 12,
    parameter int PRE   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    output logic             tone_bit
);
    localparam int CNT_W = PER_W + $clog2(PRE);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim_m1;
    logic [PER_W-1:0] per_eff;

    assign per_eff = (period == '0) ? PER_W'(1) : period;
    assign lim_m1  = CNT_W'(per_eff) * CNT_W'(PRE) - CNT_W'(1);

    // Count enabled ticks and flip the output at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            tone_bit <= 1'b0;
        end else if (tick) begin
            if (cnt >= lim_m1) begin
                cnt      <= '0;
                tone_bit <= ~tone_bit;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/psg3_noise.sv
// Noise source: 17-bit right-shifting LFSR stepped every PRE*period ticks,
// seeded with 1; output is bit 0. Assumes a period of zero behaves as one.
module psg3_noise
    import psg3_pkg::*;
#(
    parameter int PER_W = 5,
    parameter int PRE   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [PER_W-1:0]  period,
    output logic              noise_bit,
    output logic [LFSR_W-1:0] state
);
    localparam int CNT_W = PER_W + $clog2(PRE);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim_m1;
    logic [PER_W-1:0] per_eff;

    assign per_eff   = (period == '0) ? PER_W'(1) : period;
    assign lim_m1    = CNT_W'(per_eff) * CNT_W'(PRE) - CNT_W'(1);
    assign noise_bit = state[0];

    // Advance the prescaler and shift the LFSR at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            state <= LFSR_W'(1);
        end else if (tick) begin
            if (cnt >= lim_m1) begin
                cnt   <= '0;
                state <= {state[0] ^ state[LFSR_TAP], state[LFSR_W-1:1]};
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/psg3_env.sv
// Envelope generator: 16-level ramps whose direction, repetition and final
// hold follow the four shape bits. Assumes restart and the new shape arrive
// in the cycle of the shape-register write.
module psg3_env
    import psg3_pkg::*;
#(
    parameter int PER_W = 16,
    parameter int PRE   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    input  logic [3:0]       shape,
    input  logic             restart,
    input  logic [3:0]       restart_shape,
    output logic [AMP_W-1:0] level,
    output logic             holding
);
    localparam int CNT_W = PER_W + $clog2(PRE);

    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] lim_m1;
    logic [PER_W-1:0] per_eff;
    logic [AMP_W-1:0] step_cnt;
    logic             inv;
    logic             step;

    assign per_eff = (period == '0) ? PER_W'(1) : period;
    assign lim_m1  = CNT_W'(per_eff) * CNT_W'(PRE) - CNT_W'(1);
    assign step    = tick && (pcnt >= lim_m1);
    assign level   = inv ? ~step_cnt : step_cnt;

    // Step timer: counts enabled ticks, cleared by a restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            pcnt <= '0;
        else if (tick)
            pcnt <= step ? '0 : pcnt + CNT_W'(1);
    end

    // Ramp state: position, inversion and hold, updated on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_cnt <= '0;
            inv      <= 1'b1;
            holding  <= 1'b0;
        end else if (restart) begin
            step_cnt <= '0;
            inv      <= ~restart_shape[SH_ATTACK];
            holding  <= 1'b0;
        end else if (step && !holding) begin
            if (step_cnt != '1) begin
                step_cnt <= step_cnt + AMP_W'(1);
            end else if (!shape[SH_CONT]) begin
                holding <= 1'b1;
                inv     <= 1'b1;
            end else if (shape[SH_HOLD]) begin
                holding <= 1'b1;
                if (shape[SH_ALT]) inv <= ~inv;
            end else begin
                step_cnt <= '0;
                if (shape[SH_ALT]) inv <= ~inv;
            end
        end
    end
endmodule

// File: rtl/psg3_core.sv
// Top of the three-channel sound generator: register file, three tone
// dividers, noise source, envelope and per-channel mixer/volume select.
// Assumes the host respects the register map; outputs are combinational
// from internal state.
module psg3_core
    import psg3_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             bus_we,
    input  logic [3:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [7:0]       port_a_in,
    input  logic [7:0]       port_b_in,
    output logic [7:0]       port_a_out,
    output logic             port_a_oe,
    output logic [7:0]       port_b_out,
    output logic             port_b_oe,
    output logic [3:0]       amp_a,
    output logic [3:0]       amp_b,
    output logic [3:0]       amp_c,
    output logic [5:0]       amp_sum
);
    logic [NUM_CH-1:0][TONE_W-1:0] tone_per;
    logic [NOISE_W-1:0]            noise_per;
    logic [7:0]                    mixer;
    logic [NUM_CH-1:0][VOL_W-1:0]  vol;
    logic [ENV_W-1:0]              env_per;
    logic [3:0]                    env_shape;
    logic [NUM_CH-1:0]             tone_bits;
    logic                          noise_bit;
    logic [LFSR_W-1:0]             lfsr_state;
    logic [AMP_W-1:0]              env_level;
    logic                          env_hold;
    logic                          shape_wr;
    logic [NUM_CH-1:0][AMP_W-1:0]  amp;
    logic [SUM_W-1:0]              sum;

    assign shape_wr = bus_we && (bus_addr == ADDR_W'(REG_SHAPE));

    psg3_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_a_in(port_a_in), .port_b_in(port_b_in),
        .tone_per(tone_per), .noise_per(noise_per), .mixer(mixer), .vol(vol),
        .env_per(env_per), .env_shape(env_shape),
        .port_a_lat(port_a_out), .port_b_lat(port_b_out)
    );

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
            logic             ch_on;
            logic [AMP_W-1:0] ch_level;

            psg3_tone #(.PER_W(TONE_W), .PRE(PRESCALE)) u_tone (
                .clk(clk), .rst_n(rst_n), .tick(tick),
                .period(tone_per[ch]), .tone_bit(tone_bits[ch])
            );

            // Mixer gate and fixed/envelope level select for this channel.
            always_comb begin
                ch_on    = (tone_bits[ch] | mixer[ch]) & (noise_bit | mixer[ch+NUM_CH]);
                ch_level = vol[ch][AMP_W] ? env_level : vol[ch][AMP_W-1:0];
                amp[ch]  = ch_on ? ch_level : '0;
            end
        end
    endgenerate

    psg3_noise #(.PER_W(NOISE_W), .PRE(PRESCALE)) u_noise (
        .clk(clk), .rst_n(rst_n), .tick(tick), .period(noise_per),
        .noise_bit(noise_bit), .state(lfsr_state)
    );

    psg3_env #(.PER_W(ENV_W), .PRE(PRESCALE)) u_env (
        .clk(clk), .rst_n(rst_n), .tick(tick), .period(env_per),
        .shape(env_shape), .restart(shape_wr), .restart_shape(bus_wdata[3:0]),
        .level(env_level), .holding(env_hold)
    );

    // Sum the channel amplitudes.
    always_comb begin
        sum = '0;
        for (int i = 0; i < NUM_CH; i++) sum = sum + SUM_W'(amp[i]);
    end

    assign amp_a     = amp[0];
    assign amp_b     = amp[1];
    assign amp_c     = amp[2];
    assign amp_sum   = 6'(sum);
    assign port_a_oe = mixer[MIX_DIR_A];
    assign port_b_oe = mixer[MIX_DIR_B];
endmodule

// File: rtl/psg3_checker.sv
// Checker: temporal properties of the sound generator, bound into the top.
module psg3_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        bus_we,
    input logic [3:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic [7:0]  port_a_in,
    input logic        port_a_oe,
    input logic [3:0]  amp_a,
    input logic [3:0]  amp_b,
    input logic [3:0]  amp_c,
    input logic [5:0]  amp_sum,
    input logic [2:0]  tone_bits,
    input logic [16:0] lfsr,
    input logic [3:0]  env_level,
    input logic        env_hold,
    input logic [4:0]  vol_a,
    input logic [7:0]  mixer
);
    logic [3:0] sel_a;
    assign sel_a = vol_a[4] ? env_level : vol_a[3:0];

    assert_sum_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_sum >= 6'(amp_a)) && (amp_sum >= 6'(amp_b)) && (amp_sum >= 6'(amp_c)) && (amp_sum <= 6'd45));

    assert_tone_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tone_bits));

    assert_lfsr_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != 17'd0);

    assert_mix_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mixer[0] && mixer[3]) |-> (amp_a == sel_a));

    assert_level_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_a != 4'd0) |-> (amp_a == sel_a));

    assert_env_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (env_hold && !(bus_we && bus_addr == 4'd13)) |=> $stable(env_level));

    assert_env_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 4'd13) |=> (env_level == ($past(bus_wdata[2]) ? 4'd0 : 4'd15)));

    assert_port_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 4'd14 && !port_a_oe) |-> (bus_rdata == port_a_in));
endmodule

bind psg3_core psg3_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_a_in(port_a_in),
    .port_a_oe(port_a_oe), .amp_a(amp_a), .amp_b(amp_b), .amp_c(amp_c),
    .amp_sum(amp_sum), .tone_bits(tone_bits), .lfsr(lfsr_state),
    .env_level(env_level), .env_hold(env_hold), .vol_a(vol[0]), .mixer(mixer)
);

// File: tb/tb_psg3_core.sv
module tb_psg3_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] port_a_in = 8'h33;
    logic [7:0] port_b_in = 8'hC3;
    logic [7:0] port_a_out, port_b_out;
    logic       port_a_oe, port_b_oe;
    logic [3:0] amp_a, amp_b, amp_c;
    logic [5:0] amp_sum;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    psg3_core dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_a_in(port_a_in),
        .port_b_in(port_b_in), .port_a_out(port_a_out), .port_a_oe(port_a_oe),
        .port_b_out(port_b_out), .port_b_oe(port_b_oe), .amp_a(amp_a),
        .amp_b(amp_b), .amp_c(amp_c), .amp_sum(amp_sum)
    );

    // Row: {mixer, vol A, vol B, vol C, exp A, exp B, exp C, exp sum}; no ticks.
    localparam logic [49:0] VEC [7] = '{
        {8'hFF, 8'h05, 8'h0A, 8'h0F, 4'd5,  4'd10, 4'd15, 6'd30},
        {8'hF8, 8'h05, 8'h0A, 8'h0F, 4'd0,  4'd0,  4'd0,  6'd0},
        {8'hC7, 8'h05, 8'h0A, 8'h0F, 4'd5,  4'd10, 4'd15, 6'd30},
        {8'hFE, 8'h03, 8'h04, 8'h07, 4'd0,  4'd4,  4'd7,  6'd11},
        {8'hFF, 8'h10, 8'h1F, 8'h02, 4'd15, 4'd15, 4'd2,  6'd32},
        {8'hED, 8'h01, 8'h0C, 8'h0E, 4'd1,  4'd0,  4'd14, 6'd15},
        {8'hFF, 8'h00, 8'h00, 8'h00, 4'd0,  4'd0,  4'd0,  6'd0}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; bus_we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
        #1;
    endtask

    task automatic env_case(input logic [3:0] sh, input int l0, input int l240,
                            input int l256, input int l272);
        do_reset();
        wr(4'd7, 8'hFF); wr(4'd8, 8'h10); wr(4'd11, 8'd1);
        wr(4'd13, {4'd0, sh});
        check($sformatf("R8 shape %0d start", sh), amp_a, l0);
        run_ticks(240);
        check($sformatf("R7 shape %0d after 240", sh), amp_a, l240);
        run_ticks(16);
        check($sformatf("R7 shape %0d after 256", sh), amp_a, l256);
        run_ticks(16);
        check($sformatf("R7 shape %0d after 272", sh), amp_a, l272);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;

        // R1: reset state
        do_reset();
        check("R1 amp_a", amp_a, 0);
        check("R1 amp_sum", amp_sum, 0);
        check("R1 port oe", {port_a_oe, port_b_oe}, 0);
        check("R1 port out", {port_a_out, port_b_out}, 0);
        for (int i = 0; i < 14; i++) begin
            rd(4'(i), d);
            check($sformatf("R1 reg %0d", i), d, 0);
        end

        // R5, R6, R10: vector table with frozen timing
        foreach (VEC[i]) begin
            wr(4'd7, VEC[i][49:42]);
            wr(4'd8, VEC[i][41:34]);
            wr(4'd9, VEC[i][33:26]);
            wr(4'd10, VEC[i][25:18]);
            check($sformatf("R5 row %0d amp_a", i), amp_a, VEC[i][17:14]);
            check($sformatf("R6 row %0d amp_b", i), amp_b, VEC[i][13:10]);
            check($sformatf("R5 row %0d amp_c", i), amp_c, VEC[i][9:6]);
            check($sformatf("R10 row %0d sum", i), amp_sum, VEC[i][5:0]);
        end

        // R2: readback masking
        do_reset();
        wr(4'd1, 8'hFF);  rd(4'd1, d);  check("R2 coarse tone", d, 8'h0F);
        wr(4'd6, 8'hFF);  rd(4'd6, d);  check("R2 noise", d, 8'h1F);
        wr(4'd8, 8'hFF);  rd(4'd8, d);  check("R2 volume", d, 8'h1F);
        wr(4'd13, 8'hFF); rd(4'd13, d); check("R2 shape", d, 8'h0F);
        wr(4'd12, 8'hFF); rd(4'd12, d); check("R2 env coarse", d, 8'hFF);
        wr(4'd0, 8'hA5);  rd(4'd0, d);  check("R2 fine tone", d, 8'hA5);

        // R3: tone toggles at 16*P ticks, periods 1, 0, 3
        do_reset();
        wr(4'd0, 8'd1); wr(4'd2, 8'd0); wr(4'd4, 8'd3);
        wr(4'd7, 8'hF8); wr(4'd8, 8'd8); wr(4'd9, 8'd4); wr(4'd10, 8'd2);
        run_ticks(15);
        check("R3 before first toggle", amp_sum, 0);
        run_ticks(1);
        check("R3 16 ticks A", amp_a, 8);
        check("R3 period 0 as 1 B", amp_b, 4);
        check("R3 16 ticks C", amp_c, 0);
        run_ticks(31);
        check("R3 47 ticks", amp_sum, 0);
        run_ticks(1);
        check("R3 48 ticks sum", amp_sum, 14);
        repeat (100) @(posedge clk);
        #1;
        check("R3 tick low freezes", amp_sum, 14);

        // R3: period 2
        do_reset();
        wr(4'd0, 8'd2); wr(4'd7, 8'hFE); wr(4'd8, 8'd8);
        run_ticks(31);
        check("R3 period 2 at 31", amp_a, 0);
        run_ticks(1);
        check("R3 period 2 at 32", amp_a, 8);

        // R3: coarse only, period 256
        do_reset();
        wr(4'd1, 8'd1); wr(4'd7, 8'hFE); wr(4'd8, 8'd8);
        run_ticks(4095);
        check("R3 coarse at 4095", amp_a, 0);
        run_ticks(1);
        check("R3 coarse at 4096", amp_a, 8);

        // R4: noise only on A, period 1
        do_reset();
        wr(4'd6, 8'd1); wr(4'd7, 8'hF7); wr(4'd8, 8'd9);
        run_ticks(15);
        check("R4 noise seed bit", amp_a, 9);
        run_ticks(1);
        check("R4 after first shift", amp_a, 0);
        run_ticks(240);
        check("R4 after 16 shifts", amp_a, 0);
        run_ticks(16);
        check("R4 after 17 shifts", amp_a, 9);

        // R7, R8: envelope shapes, period 1
        env_case(4'd13, 0, 15, 15, 15);
        env_case(4'd8, 15, 0, 15, 14);
        env_case(4'd0, 15, 0, 0, 0);
        env_case(4'd14, 0, 15, 15, 14);
        env_case(4'd11, 15, 0, 15, 15);
        env_case(4'd4, 0, 15, 0, 0);
        env_case(4'd10, 15, 0, 0, 1);
        env_case(4'd15, 0, 15, 0, 0);
        wr(4'd13, 8'd8);
        check("R8 rewrite restarts", amp_a, 15);
        wr(4'd11, 8'd2); wr(4'd13, 8'd12);
        run_ticks(31);
        check("R7 period 2 at 31", amp_a, 0);
        run_ticks(1);
        check("R7 period 2 at 32", amp_a, 1);

        // R8: reset envelope level is 15
        do_reset();
        wr(4'd7, 8'hFF); wr(4'd8, 8'h10);
        check("R8 reset level", amp_a, 15);

        // R9: ports
        do_reset();
        rd(4'd14, d); check("R9 A input pins", d, 8'h33);
        wr(4'd14, 8'h5A);
        check("R9 A latch out", port_a_out, 8'h5A);
        rd(4'd14, d); check("R9 A still input", d, 8'h33);
        wr(4'd7, 8'h40);
        check("R9 A oe", port_a_oe, 1);
        rd(4'd14, d); check("R9 A output read", d, 8'h5A);
        rd(4'd15, d); check("R9 B input pins", d, 8'hC3);
        wr(4'd15, 8'h81);
        check("R9 B oe off", port_b_oe, 0);
        wr(4'd7, 8'h80);
        check("R9 B oe on", port_b_oe, 1);
        rd(4'd15, d); check("R9 B output read", d, 8'h81);
        rd(4'd14, d); check("R9 A back to input", d, 8'h33);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule